// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a processor core that completes one instruction per clock. In each cycle it presents the program counter on the instruction port and takes back a 32-bit instruction word. It decodes that word, reads two operands from a 32-entry register file, and computes a result. It then commits the result, a memory store or a new program counter at the next rising edge. The supported set covers register-to-register arithmetic, logic and shifts, immediate arithmetic and logic, upper-half constant loads, word loads and stores, two conditional branches, an absolute jump and a register jump.

Both memory ports are plain word ports that answer within the same cycle. There is no valid/ready handshake and no back-pressure. The instruction word must be stable while its address is presented. Load data must follow `dmem_addr` combinationally. A store is committed by the memory at the rising edge that ends any cycle in which `dmem_we` is high. Three status pins describe the instruction executing in the current cycle: signed overflow, misaligned word access and undefined encoding. Each is high only during that instruction's cycle.

Top module: `rc_core`

## Requirements
- R1: After reset the core fetches from 0x00400000. Each instruction that does not redirect control is followed by a fetch from its address plus 4.
- R2: Register 0 reads as zero as a source, and any result aimed at it is dropped.
- R3: With opcode bits [31:26] = 0, funct bits [5:0] select the operation, with operands rs [25:21] and rt [20:16], result to rd [15:11]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR. Subtract wraps.
- R4: The shift funct codes shift rt and write rd. Codes 0x00 (left), 0x02 (right logical) and 0x03 (right arithmetic) use the amount in bits [10:6]. Codes 0x04, 0x06 and 0x07 do the same three shifts with the amount taken from rs[4:0].
- R5: When funct 0x20 or opcode 0x08 overflows as a signed sum, `ovf_flag` is high in that cycle and the destination keeps its old value. No other operation raises it.
- R6: Opcode 0x08 adds the sign-extended 16-bit immediate (bits [15:0]) to rs and writes rt. Opcodes 0x0C, 0x0D and 0x0E do AND, OR and XOR of rs with the zero-extended immediate, written to rt.
- R7: Opcode 0x0F writes the immediate to rt[31:16] and zeros to rt[15:0].
- R8: Opcode 0x23 loads rt from address rs plus the sign-extended immediate. Opcode 0x2B drives that address, the rt value and `dmem_we` high.
- R9: For a load or store whose address has a nonzero bit 1 or bit 0, `align_err` is high, no store is issued and no register is written.
- R10: Opcode 0x04 (branch if rs equals rt) and opcode 0x05 (branch if they differ) go to PC+4 plus the sign-extended immediate times 4 when the condition holds. Otherwise they go to PC+4.
- R11: Opcode 0x02 goes to {PC+4 bits [31:28], bits [25:0] of the word, 00}. Opcode 0 with funct 0x08 goes to the value of rs.
- R12: An undefined opcode, or an undefined funct under opcode 0, raises `illegal_flag`, writes neither register nor memory, and continues at PC+4.
- R13: The words 0x20030007, 0x20040009 and 0x00642820, executed in that order, leave 16 in register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Address of the instruction being executed |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data word address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, same cycle |
| ovf_flag | output | 1 | Signed overflow on the current add |
| align_err | output | 1 | Current load or store address is not word aligned |
| illegal_flag | output | 1 | Current instruction word is undefined |

## Verification
The hardest case to reach from the ports is a suppressed write: an overflowing add, a misaligned load, or an undefined word aimed at a register. Nothing is visible at the ports when such a write is correctly dropped. The bench therefore first plants a marker value in the destination with an OR-immediate. It then runs the instruction under test and reads the destination back with a store to address 0. Operand pairs that cross the sign boundary are built with upper-half loads, so that every overflow corner of add and add-immediate is swept.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_UPPER
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu;
    logic    use_imm;
    logic    zext;
    logic    wr_reg;
    logic    to_rd;
    logic    var_sh;
    logic    ld;
    logic    st;
    logic    beq;
    logic    bne;
    logic    jmp;
    logic    jreg;
    logic    chk_ovf;
    logic    bad;
  } ctrl_t;
endpackage

// File: rtl/rc_decode.sv
module rc_decode
  import rc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] fn,
  output ctrl_t      ctl
);
  always_comb begin
    ctl     = '0;
    ctl.alu = ALU_ADD;
    case (op)
      OP_RTYPE: begin
        ctl.wr_reg = 1'b1;
        ctl.to_rd  = 1'b1;
        case (fn)
          FN_ADD:  ctl.chk_ovf = 1'b1;
          FN_SUB:  ctl.alu = ALU_SUB;
          FN_AND:  ctl.alu = ALU_AND;
          FN_OR:   ctl.alu = ALU_OR;
          FN_XOR:  ctl.alu = ALU_XOR;
          FN_NOR:  ctl.alu = ALU_NOR;
          FN_SLL:  ctl.alu = ALU_SLL;
          FN_SRL:  ctl.alu = ALU_SRL;
          FN_SRA:  ctl.alu = ALU_SRA;
          FN_SLLV: begin ctl.alu = ALU_SLL; ctl.var_sh = 1'b1; end
          FN_SRLV: begin ctl.alu = ALU_SRL; ctl.var_sh = 1'b1; end
          FN_SRAV: begin ctl.alu = ALU_SRA; ctl.var_sh = 1'b1; end
          FN_JR:   begin ctl.wr_reg = 1'b0; ctl.jreg = 1'b1; end
          default: begin ctl.wr_reg = 1'b0; ctl.to_rd = 1'b0; ctl.bad = 1'b1; end
        endcase
      end
      OP_ADDI: begin ctl.use_imm = 1'b1; ctl.wr_reg = 1'b1; ctl.chk_ovf = 1'b1; end
      OP_ANDI: begin ctl.alu = ALU_AND; ctl.use_imm = 1'b1; ctl.zext = 1'b1; ctl.wr_reg = 1'b1; end
      OP_ORI:  begin ctl.alu = ALU_OR;  ctl.use_imm = 1'b1; ctl.zext = 1'b1; ctl.wr_reg = 1'b1; end
      OP_XORI: begin ctl.alu = ALU_XOR; ctl.use_imm = 1'b1; ctl.zext = 1'b1; ctl.wr_reg = 1'b1; end
      OP_LUI:  begin ctl.alu = ALU_UPPER; ctl.use_imm = 1'b1; ctl.zext = 1'b1; ctl.wr_reg = 1'b1; end
      OP_LW:   begin ctl.use_imm = 1'b1; ctl.wr_reg = 1'b1; ctl.ld = 1'b1; end
      OP_SW:   begin ctl.use_imm = 1'b1; ctl.st = 1'b1; end
      OP_BEQ:  ctl.beq = 1'b1;
      OP_BNE:  ctl.bne = 1'b1;
      OP_J:    ctl.jmp = 1'b1;
      default: ctl.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W),
  localparam int HW  = W / 2
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   y,
  output logic           ovf
);
  logic [W-1:0] sum;
  assign sum = a + b;
  assign ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);

  always_comb begin
    case (op)
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_NOR:   y = ~(a | b);
      ALU_SLL:   y = b << sh;
      ALU_SRL:   y = b >> sh;
      ALU_SRA:   y = $unsigned($signed(b) >>> sh);
      ALU_UPPER: y = {b[HW-1:0], {HW{1'b0}}};
      default:   y = sum;
    endcase
  end
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we && wa != '0) begin
      mem[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0040_0000,
  localparam int IMMW = 16,
  localparam int AW   = $clog2(NREG),
  localparam int SHW  = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_data,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  input  logic [W-1:0] dmem_rdata,
  output logic         ovf_flag,
  output logic         align_err,
  output logic         illegal_flag
);
  logic [W-1:0] pc_q, pc4, pc_next, br_tgt, jmp_tgt;
  logic [W-1:0] ext, rs_val, rt_val, alu_b, alu_y, wb_data;
  logic [AW-1:0] rs_idx, rt_idx, rd_idx, wa;
  logic [SHW-1:0] sh_fld, sh_amt;
  logic [IMMW-1:0] imm;
  logic alu_ovf, take_br, rf_we;
  ctrl_t ctl;

  assign rs_idx = imem_data[25:21];
  assign rt_idx = imem_data[20:16];
  assign rd_idx = imem_data[15:11];
  assign sh_fld = imem_data[10:6];
  assign imm    = imem_data[IMMW-1:0];

  rc_decode u_dec (.op(imem_data[31:26]), .fn(imem_data[5:0]), .ctl(ctl));

  assign ext    = ctl.zext ? {{(W-IMMW){1'b0}}, imm} : {{(W-IMMW){imm[IMMW-1]}}, imm};
  assign alu_b  = ctl.use_imm ? ext : rt_val;
  assign sh_amt = ctl.var_sh ? rs_val[SHW-1:0] : sh_fld;

  rc_regfile #(.W(W), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra1(rs_idx), .ra2(rt_idx),
    .rd1(rs_val), .rd2(rt_val), .we(rf_we), .wa(wa), .wd(wb_data)
  );

  rc_alu #(.W(W)) u_alu (
    .op(ctl.alu), .a(rs_val), .b(alu_b), .sh(sh_amt), .y(alu_y), .ovf(alu_ovf)
  );

  // status for the current instruction
  assign ovf_flag     = ctl.chk_ovf & alu_ovf;
  assign align_err    = (ctl.ld | ctl.st) & (|alu_y[1:0]);
  assign illegal_flag = ctl.bad;

  // write-back
  assign wa      = ctl.to_rd ? rd_idx : rt_idx;
  assign wb_data = ctl.ld ? dmem_rdata : alu_y;
  assign rf_we   = ctl.wr_reg & ~ovf_flag & ~(ctl.ld & align_err);

  // data port
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.st & ~align_err;

  // next PC
  assign pc4     = pc_q + W'(4);
  assign br_tgt  = pc4 + {ext[W-3:0], 2'b00};
  assign jmp_tgt = {pc4[W-1:W-4], imem_data[W-7:0], 2'b00};
  assign take_br = (ctl.beq & (rs_val == rt_val)) | (ctl.bne & (rs_val != rt_val));

  always_comb begin
    if (ctl.jreg)      pc_next = rs_val;
    else if (ctl.jmp)  pc_next = jmp_tgt;
    else if (take_br)  pc_next = br_tgt;
    else               pc_next = pc4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  // R1: fall-through advances by one word
  p_seq_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_br && !ctl.jmp && !ctl.jreg) |=> (pc_q == $past(pc4)));
  // R10: taken branch lands on the computed target
  p_branch_tgt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_br |=> (pc_q == $past(br_tgt)));
  // R11: register jump follows rs
  p_jreg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.jreg |=> (pc_q == $past(rs_val)));
  // R5: overflowing add never writes the register file
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> !rf_we);
  // R9: misaligned access issues no store and no write-back
  p_no_misaligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!dmem_we && !(ctl.ld && rf_we)));
  // R12: undefined words touch no state
  p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_flag |-> (!rf_we && !dmem_we));
endmodule

// File: tb/sim_rc_core.sv
module sim_rc_core;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data = 32'h0, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we, ovf_flag, align_err, illegal_flag;
  logic [31:0] dm [64];

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [31:0] c_pc, c_addr, c_wd;
  logic c_we, c_ovf, c_al, c_ill;

  always #(CLK_P/2) clk = ~clk;

  rc_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .ovf_flag(ovf_flag), .align_err(align_err),
    .illegal_flag(illegal_flag)
  );

  assign dmem_rdata = dm[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction
  function automatic logic [31:0] rr(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a negedge; drive, capture mid-cycle, advance one edge
  task automatic step(input logic [31:0] ins);
    imem_data = ins;
    #1;
    c_pc = imem_addr; c_we = dmem_we; c_addr = dmem_addr; c_wd = dmem_wdata;
    c_ovf = ovf_flag; c_al = align_err; c_ill = illegal_flag;
    @(negedge clk);
  endtask

  task automatic setr(input logic [4:0] r, input logic [31:0] v);
    step(ri(6'h0F, 5'd0, r, v[31:16]));
    step(ri(6'h0D, r, r, v[15:0]));
  endtask

  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    step(ri(6'h2B, 5'd0, r, 16'h0));
    v = c_wd;
  endtask

  function automatic logic [31:0] exp_r(input logic [5:0] fn, input logic [31:0] a, b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h26: return a ^ b;
      6'h27: return ~(a | b);
      6'h04: return b << a[4:0];
      6'h06: return b >> a[4:0];
      default: return $unsigned($signed(b) >>> a[4:0]);
    endcase
  endfunction

  function automatic logic sovf(input logic [31:0] a, b);
    logic [31:0] s;
    s = a + b;
    return (a[31] == b[31]) && (s[31] != a[31]);
  endfunction

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                            32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_FA34, 32'hA5A5_A5A5};
  logic [15:0] imms [6] = '{16'h0, 16'h0007, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFA34};
  logic [5:0]  rfns [9] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h04, 6'h06, 6'h07};
  logic [5:0]  iops [5] = '{6'h08, 6'h0C, 6'h0D, 6'h0E, 6'h0F};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e, a, b, bpc;
    logic eo;
    for (int i = 0; i < 64; i++) dm[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset fetch address and sequencing
    step(32'h0);
    chk("R1 reset pc", c_pc, 32'h0040_0000);
    step(32'h0);
    chk("R1 pc+4", c_pc, 32'h0040_0004);

    // R13 reference program
    step(32'h2003_0007); step(32'h2004_0009); step(32'h0064_2820);
    peek(5'd5, v);
    chk("R13 r5", v, 32'd16);

    // R2 register zero
    step(ri(6'h08, 5'd0, 5'd0, 16'h0005));
    peek(5'd0, v);
    chk("R2 r0 after addi", v, 32'h0);
    setr(5'd1, 32'h1234_5678);
    step(rr(5'd1, 5'd1, 5'd0, 5'd0, 6'h25));
    step(rr(5'd0, 5'd0, 5'd3, 5'd0, 6'h25));
    peek(5'd3, v);
    chk("R2 r0 as source", v, 32'h0);

    // R3 R4 R5 register-register sweep
    foreach (rfns[f]) for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) begin
      a = vals[i]; b = vals[j];
      setr(5'd1, a); setr(5'd2, b);
      step(ri(6'h0D, 5'd0, 5'd3, 16'hBEEF));
      step(rr(5'd1, 5'd2, 5'd3, 5'd0, rfns[f]));
      eo = (rfns[f] == 6'h20) && sovf(a, b);
      chk("R5 ovf flag rr", {31'h0, c_ovf}, {31'h0, eo});
      peek(5'd3, v);
      e = eo ? 32'h0000_BEEF : exp_r(rfns[f], a, b);
      if (rfns[f] inside {6'h04, 6'h06, 6'h07}) chk("R4 var shift", v, e);
      else chk("R3 rr op", v, e);
    end

    // R4 fixed shifts
    for (int i = 0; i < 8; i++) for (int s = 0; s < 32; s++) for (int k = 0; k < 3; k++) begin
      logic [5:0] fn;
      fn = (k == 0) ? 6'h00 : (k == 1) ? 6'h02 : 6'h03;
      setr(5'd2, vals[i]);
      step(rr(5'd0, 5'd2, 5'd3, 5'(s), fn));
      peek(5'd3, v);
      e = (k == 0) ? vals[i] << s : (k == 1) ? vals[i] >> s : $unsigned($signed(vals[i]) >>> s);
      chk("R4 fixed shift", v, e);
    end

    // R5 R6 R7 immediate sweep
    foreach (iops[o]) for (int i = 0; i < 8; i++) foreach (imms[m]) begin
      logic [31:0] se, ze;
      a = vals[i];
      se = {{16{imms[m][15]}}, imms[m]}; ze = {16'h0, imms[m]};
      setr(5'd1, a);
      step(ri(6'h0D, 5'd0, 5'd3, 16'hBEEF));
      step(ri(iops[o], 5'd1, 5'd3, imms[m]));
      eo = (iops[o] == 6'h08) && sovf(a, se);
      chk("R5 ovf flag imm", {31'h0, c_ovf}, {31'h0, eo});
      peek(5'd3, v);
      case (iops[o])
        6'h08: e = eo ? 32'h0000_BEEF : a + se;
        6'h0C: e = a & ze;
        6'h0D: e = a | ze;
        6'h0E: e = a ^ ze;
        default: e = {imms[m], 16'h0};
      endcase
      if (iops[o] == 6'h0F) chk("R7 upper load", v, e);
      else chk("R6 imm op", v, e);
    end

    // R8 loads and stores
    setr(5'd1, 32'h0000_0100); setr(5'd2, 32'hCAFE_F00D);
    step(ri(6'h2B, 5'd1, 5'd2, 16'hFFFC));
    chk("R8 sw we", {31'h0, c_we}, 32'h1);
    chk("R8 sw addr", c_addr, 32'h0000_00FC);
    chk("R8 sw data", c_wd, 32'hCAFE_F00D);
    step(ri(6'h23, 5'd1, 5'd4, 16'hFFFC));
    peek(5'd4, v);
    chk("R8 lw data", v, 32'hCAFE_F00D);

    // R9 misaligned
    step(ri(6'h2B, 5'd1, 5'd2, 16'h0002));
    chk("R9 sw align flag", {31'h0, c_al}, 32'h1);
    chk("R9 sw suppressed", {31'h0, c_we}, 32'h0);
    step(ri(6'h0D, 5'd0, 5'd4, 16'h4444));
    step(ri(6'h23, 5'd0, 5'd4, 16'h00FD));
    chk("R9 lw align flag", {31'h0, c_al}, 32'h1);
    peek(5'd4, v);
    chk("R9 lw no write", v, 32'h0000_4444);

    // R10 branches
    setr(5'd1, 32'h5); setr(5'd2, 32'h5); setr(5'd3, 32'h6);
    step(ri(6'h04, 5'd1, 5'd2, 16'h0003)); bpc = c_pc;
    step(32'h0);
    chk("R10 beq taken", c_pc, bpc + 32'd16);
    step(ri(6'h05, 5'd1, 5'd2, 16'h0003)); bpc = c_pc;
    step(32'h0);
    chk("R10 bne not taken", c_pc, bpc + 32'd4);
    step(ri(6'h05, 5'd1, 5'd3, 16'hFFFE)); bpc = c_pc;
    step(32'h0);
    chk("R10 bne back", c_pc, bpc - 32'd4);
    step(ri(6'h04, 5'd1, 5'd3, 16'h0010)); bpc = c_pc;
    step(32'h0);
    chk("R10 beq not taken", c_pc, bpc + 32'd4);

    // R11 jumps
    step({6'h02, 26'h012_3456}); bpc = c_pc;
    step(32'h0);
    chk("R11 j target", c_pc, {bpc[31:28] + 4'h0, 26'h012_3456, 2'b00});
    setr(5'd1, 32'h0040_0200);
    step(rr(5'd1, 5'd0, 5'd0, 5'd0, 6'h08));
    step(32'h0);
    chk("R11 jr target", c_pc, 32'h0040_0200);

    // R12 undefined encodings
    step(ri(6'h0D, 5'd0, 5'd3, 16'hBEEF));
    step(ri(6'h3F, 5'd0, 5'd3, 16'h1234)); bpc = c_pc;
    chk("R12 illegal op flag", {31'h0, c_ill}, 32'h1);
    chk("R12 illegal op no store", {31'h0, c_we}, 32'h0);
    step(rr(5'd1, 5'd1, 5'd3, 5'd0, 6'h01));
    chk("R12 pc+4", c_pc, bpc + 32'd4);
    chk("R12 illegal funct flag", {31'h0, c_ill}, 32'h1);
    peek(5'd3, v);
    chk("R12 r3 kept", v, 32'h0000_BEEF);
    chk("R12 no flag on store", {31'h0, c_ill}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule